// File: doc/BRIEF.md
# Conditional DMA Load Unit

This block executes the load step of one DMA channel thread. It takes a single opcode byte from the channel's instruction issue logic and decodes it. For a load opcode it decides whether the load runs or becomes a no-operation. A conditional load carries a single or burst suffix, and it runs only when that suffix matches a request-type flag. That flag is set elsewhere by a wait-for-peripheral instruction, and this block only reads it.

When the load runs, the unit issues one AXI read-address request. A single-form load always asks for exactly one beat. The unconditional form and the burst form take their length from the channel's burst-length control field. Every returned read beat is written into a shared data FIFO, together with the channel number as a tag. On the last beat the unit retires the instruction: it pulses a program-counter advance and, in incrementing mode, a source-address update.

The opcode enters over a valid/ready handshake. `op_ready` is high only while the unit is idle, and an opcode counts as taken on a clock edge where both signals are high. Read data is sunk with `rready`, which drops whenever the FIFO reports full. The AR channel follows the usual rule: once `arvalid` is raised it stays high, and the request fields do not change, until `arready` is seen.

Top module: `dma_cond_load`

## Requirements
- R1: An opcode byte whose bits [7:2] equal 6'b000001 is a load, with bit 1 giving the burst suffix and bit 0 marking the load as conditional. Any other byte is accepted and then ignored: no AR request, no FIFO write, no PC advance, and busy stays low.
- R2: A load with bit 0 = 0 always executes, whatever the value of bit 1 and whatever the request-type flag (`req_is_burst`). Its `arlen` comes from the burst-length field.
- R3: The single form (bit 0 = 1, bit 1 = 0) executes only when `req_is_burst` = 0. When it executes, `arlen` is 0, whatever the programmed burst length.
- R4: The burst form (bit 0 = 1, bit 1 = 1) executes only when `req_is_burst` = 1. When it executes, `arlen` is the burst-length field minus one.
- R5: A conditional load whose suffix does not match the flag is skipped. `pc_adv` is high for exactly the one cycle after acceptance. There is no AR request and no FIFO write, `addr_wr` stays low, and `busy` stays low.
- R6: The first cycle after an executing load is accepted, `arvalid` rises carrying the values sampled at acceptance: `araddr` = `src_addr`, `arsize` = `ctl_size`, and `arburst` = 2'b01 when incrementing, otherwise 2'b00. These values hold until `arready`.
- R7: During the data phase, `rready` = NOT `fifo_full`. `fifo_wr` is high only when `rvalid` and `rready` are both high. `fifo_wdata` = `rdata`, and `fifo_wtag` = the `chan_id` sampled at acceptance.
- R8: The cycle after the beat with `rlast` is written, `pc_adv` pulses for exactly one cycle and `busy` is low.
- R9: With `ctl_src_inc` = 1, `addr_wr` pulses together with that `pc_adv`, and `addr_next` = `src_addr` + (`arlen`+1) << `arsize`. With `ctl_src_inc` = 0, `addr_wr` stays low.
- R10: `busy` is high from the cycle after an executing load is accepted until its last beat is stored. While `busy` is high, `op_ready` is low and no opcode is taken. After reset, `op_ready` is high and `busy` is low.
- R11: A burst-length field of 0 is treated as one beat (`arlen` = 0). A field value above 16 is clamped to sixteen beats (`arlen` = 15).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode byte offered |
| op_ready | output | 1 | Unit idle, opcode will be taken |
| op_byte | input | 8 | Opcode byte |
| req_is_burst | input | 1 | Request-type flag: 1 burst, 0 single |
| src_addr | input | AW | Current source address |
| ctl_src_inc | input | 1 | Source address increments after a load |
| ctl_burst_len | input | BL_W | Programmed beats per burst (1..16) |
| ctl_size | input | SZ_W | Beat size, log2 of bytes |
| chan_id | input | CW | Channel number used as FIFO tag |
| arvalid | output | 1 | Read-address request valid |
| arready | input | 1 | Read-address request taken |
| araddr | output | AW | Read address |
| arlen | output | LEN_W | Beats minus one |
| arsize | output | SZ_W | Beat size |
| arburst | output | 2 | 01 incrementing, 00 fixed |
| rvalid | input | 1 | Read beat valid |
| rready | output | 1 | Read beat sink ready |
| rdata | input | DW | Read beat data |
| rlast | input | 1 | Final beat of the burst |
| fifo_wr | output | 1 | Data FIFO write strobe |
| fifo_wdata | output | DW | Data FIFO write data |
| fifo_wtag | output | CW | Channel tag for the written entry |
| fifo_full | input | 1 | Data FIFO cannot take an entry |
| pc_adv | output | 1 | One-cycle channel PC advance |
| addr_wr | output | 1 | One-cycle source-address update strobe |
| addr_next | output | AW | New source address, valid with addr_wr |
| busy | output | 1 | Load in progress |

## Verification
A wrong execute-or-skip decision shows up in the first cycle after acceptance. Either `arvalid` rises when `pc_adv` should have pulsed, or the reverse happens. A corrupted length or latched address is visible on the AR fields in that same cycle. A miscounted beat or a lost `rlast` shows as `busy` staying high, or `pc_adv` appearing at the wrong cycle, right after the final beat. A stale tag or a wrong step size appears on `fifo_wtag` at the first write, or on `addr_next` at retirement.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  // Upper six opcode bits that identify a load.
  localparam logic [5:0] LOAD_OPC    = 6'b000001;
  localparam logic [1:0] BURST_FIXED = 2'b00;
  localparam logic [1:0] BURST_INCR  = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA
  } dcl_state_e;

  typedef struct packed {
    logic is_load;
    logic cond;
    logic want_burst;
  } dcl_op_t;
endpackage

// File: rtl/dcl_decode.sv
module dcl_decode
  import dcl_pkg::*;
(
  input  logic [7:0] op_byte,
  input  logic       req_is_burst,
  output logic       run,
  output logic       skip,
  output logic       single_form
);
  dcl_op_t f;

  always_comb begin
    f.is_load    = (op_byte[7:2] == LOAD_OPC);
    f.cond       = op_byte[0];
    f.want_burst = op_byte[1];
    // Conditional forms run only when their suffix matches the flag.
    run          = f.is_load && (!f.cond || (f.want_burst == req_is_burst));
    skip         = f.is_load && !run;
    single_form  = f.is_load && f.cond && !f.want_burst;
  end
endmodule

// File: rtl/dcl_len_sel.sv
module dcl_len_sel #(
  parameter int BL_W  = 5,
  parameter int LEN_W = 4
) (
  input  logic             single_form,
  input  logic [BL_W-1:0]  burst_len,
  output logic [LEN_W-1:0] arlen
);
  localparam int              MAX_BEATS = 1 << LEN_W;
  localparam logic [BL_W-1:0] MAX_V     = BL_W'(MAX_BEATS);

  always_comb begin
    if (single_form) begin
      arlen = '0;
    end else if (burst_len == '0) begin
      arlen = '0;
    end else if (burst_len > MAX_V) begin
      arlen = LEN_W'(MAX_BEATS - 1);
    end else begin
      arlen = LEN_W'(burst_len - BL_W'(1));
    end
  end
endmodule

// File: rtl/dcl_addr_step.sv
module dcl_addr_step #(
  parameter int AW    = 32,
  parameter int LEN_W = 4,
  parameter int SZ_W  = 3
) (
  input  logic [AW-1:0]    base,
  input  logic [LEN_W-1:0] arlen,
  input  logic [SZ_W-1:0]  size,
  output logic [AW-1:0]    next
);
  logic [AW-1:0] beats;
  logic [AW-1:0] step;

  always_comb begin
    beats = AW'(arlen) + AW'(1);
    step  = beats << size;
    next  = base + step;
  end
endmodule

// File: rtl/dcl_beat_sink.sv
module dcl_beat_sink #(
  parameter int DW = 32,
  parameter int CW = 3
) (
  input  logic          active,
  input  logic          rvalid,
  input  logic          rlast,
  input  logic [DW-1:0] rdata,
  input  logic          fifo_full,
  input  logic [CW-1:0] tag,
  output logic          rready,
  output logic          fifo_wr,
  output logic [DW-1:0] fifo_wdata,
  output logic [CW-1:0] fifo_wtag,
  output logic          last_done
);
  always_comb begin
    rready     = active && !fifo_full;
    fifo_wr    = rvalid && rready;
    last_done  = fifo_wr && rlast;
    fifo_wdata = rdata;
    fifo_wtag  = tag;
  end
endmodule

// File: rtl/dma_cond_load.sv
module dma_cond_load
  import dcl_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 3,
  parameter int BL_W  = 5,
  parameter int LEN_W = 4,
  parameter int SZ_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [7:0]       op_byte,
  input  logic             req_is_burst,
  input  logic [AW-1:0]    src_addr,
  input  logic             ctl_src_inc,
  input  logic [BL_W-1:0]  ctl_burst_len,
  input  logic [SZ_W-1:0]  ctl_size,
  input  logic [CW-1:0]    chan_id,
  output logic             arvalid,
  input  logic             arready,
  output logic [AW-1:0]    araddr,
  output logic [LEN_W-1:0] arlen,
  output logic [SZ_W-1:0]  arsize,
  output logic [1:0]       arburst,
  input  logic             rvalid,
  output logic             rready,
  input  logic [DW-1:0]    rdata,
  input  logic             rlast,
  output logic             fifo_wr,
  output logic [DW-1:0]    fifo_wdata,
  output logic [CW-1:0]    fifo_wtag,
  input  logic             fifo_full,
  output logic             pc_adv,
  output logic             addr_wr,
  output logic [AW-1:0]    addr_next,
  output logic             busy
);
  dcl_state_e       state_q;
  logic [AW-1:0]    araddr_q;
  logic [LEN_W-1:0] arlen_q;
  logic [SZ_W-1:0]  arsize_q;
  logic             inc_q;
  logic [CW-1:0]    chan_q;
  logic             pc_adv_q;
  logic             addr_wr_q;
  logic [AW-1:0]    addr_next_q;

  logic             accept;
  logic             run;
  logic             skip;
  logic             single_form;
  logic [LEN_W-1:0] len_sel;
  logic [AW-1:0]    step_next;
  logic             last_done;

  assign op_ready = (state_q == ST_IDLE);
  assign accept   = op_valid && op_ready;

  dcl_decode u_dec (
    .op_byte      (op_byte),
    .req_is_burst (req_is_burst),
    .run          (run),
    .skip         (skip),
    .single_form  (single_form)
  );

  dcl_len_sel #(.BL_W(BL_W), .LEN_W(LEN_W)) u_len (
    .single_form (single_form),
    .burst_len   (ctl_burst_len),
    .arlen       (len_sel)
  );

  dcl_addr_step #(.AW(AW), .LEN_W(LEN_W), .SZ_W(SZ_W)) u_step (
    .base  (araddr_q),
    .arlen (arlen_q),
    .size  (arsize_q),
    .next  (step_next)
  );

  dcl_beat_sink #(.DW(DW), .CW(CW)) u_sink (
    .active     (state_q == ST_DATA),
    .rvalid     (rvalid),
    .rlast      (rlast),
    .rdata      (rdata),
    .fifo_full  (fifo_full),
    .tag        (chan_q),
    .rready     (rready),
    .fifo_wr    (fifo_wr),
    .fifo_wdata (fifo_wdata),
    .fifo_wtag  (fifo_wtag),
    .last_done  (last_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      araddr_q    <= '0;
      arlen_q     <= '0;
      arsize_q    <= '0;
      inc_q       <= 1'b0;
      chan_q      <= '0;
      pc_adv_q    <= 1'b0;
      addr_wr_q   <= 1'b0;
      addr_next_q <= '0;
    end else begin
      pc_adv_q  <= (accept && skip) || last_done;
      addr_wr_q <= last_done && inc_q;
      if (last_done) begin
        addr_next_q <= step_next;
      end
      unique case (state_q)
        ST_IDLE: begin
          if (accept && run) begin
            araddr_q <= src_addr;
            arlen_q  <= len_sel;
            arsize_q <= ctl_size;
            inc_q    <= ctl_src_inc;
            chan_q   <= chan_id;
            state_q  <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (arready) begin
            state_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (last_done) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign arvalid   = (state_q == ST_ADDR);
  assign araddr    = araddr_q;
  assign arlen     = arlen_q;
  assign arsize    = arsize_q;
  assign arburst   = inc_q ? BURST_INCR : BURST_FIXED;
  assign pc_adv    = pc_adv_q;
  assign addr_wr   = addr_wr_q;
  assign addr_next = addr_next_q;
  assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/dma_cond_load_chk.sv
module dma_cond_load_chk #(
  parameter int AW    = 32,
  parameter int LEN_W = 4,
  parameter int SZ_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_ready,
  input logic             arvalid,
  input logic             arready,
  input logic [AW-1:0]    araddr,
  input logic [LEN_W-1:0] arlen,
  input logic [SZ_W-1:0]  arsize,
  input logic             rvalid,
  input logic             rready,
  input logic             rlast,
  input logic             fifo_wr,
  input logic             fifo_full,
  input logic             pc_adv,
  input logic             addr_wr,
  input logic             busy
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) fifo_wr |-> !fifo_full); // R7
  AST_WRITE_ON_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n) fifo_wr |-> (rvalid && rready)); // R7
  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (arvalid && !arready) |=> (arvalid && $stable(araddr) && $stable(arlen) && $stable(arsize))); // R6
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !op_ready); // R10
  AST_ADDR_WITH_PC: assert property (@(posedge clk) disable iff (!rst_n) addr_wr |-> pc_adv); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!arvalid && !rready && !fifo_wr)); // R5
  AST_RETIRE: assert property (@(posedge clk) disable iff (!rst_n) (fifo_wr && rlast) |=> (pc_adv && !busy)); // R8
endmodule

bind dma_cond_load dma_cond_load_chk #(.AW(AW), .LEN_W(LEN_W), .SZ_W(SZ_W)) u_chk (.*);

// File: tb/dma_cond_load_test.sv
module dma_cond_load_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic        op_ready;
  logic [7:0]  op_byte;
  logic        req_is_burst;
  logic [31:0] src_addr;
  logic        ctl_src_inc;
  logic [4:0]  ctl_burst_len;
  logic [2:0]  ctl_size;
  logic [2:0]  chan_id;
  logic        arvalid;
  logic        arready;
  logic [31:0] araddr;
  logic [3:0]  arlen;
  logic [2:0]  arsize;
  logic [1:0]  arburst;
  logic        rvalid;
  logic        rready;
  logic [31:0] rdata;
  logic        rlast;
  logic        fifo_wr;
  logic [31:0] fifo_wdata;
  logic [2:0]  fifo_wtag;
  logic        fifo_full;
  logic        pc_adv;
  logic        addr_wr;
  logic [31:0] addr_next;
  logic        busy;

  int n_checks = 0;
  int n_fail   = 0;

  always #(PERIOD / 2) clk = ~clk;

  dma_cond_load uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  function automatic bit exp_is_load(input logic [7:0] op);
    return op[7:2] == 6'b000001;
  endfunction

  function automatic bit exp_runs(input logic [7:0] op, input bit bflag);
    return exp_is_load(op) && (!op[0] || (op[1] == bflag));
  endfunction

  function automatic int exp_arlen(input logic [7:0] op, input logic [4:0] bl);
    if (op[0] && !op[1]) return 0;
    if (bl == 0) return 0;
    if (bl > 16) return 15;
    return int'(bl) - 1;
  endfunction

  function automatic string len_req(input logic [7:0] op, input logic [4:0] bl);
    if (op[0] && !op[1]) return "R3";
    if (bl == 0 || bl > 16) return "R11";
    if (op[0]) return "R4";
    return "R2";
  endfunction

  task automatic run_op(input logic [7:0] op, input bit bflag, input logic [31:0] addr,
                        input bit inc, input logic [4:0] bl, input logic [2:0] sz,
                        input logic [2:0] ch, input int full_pct);
    bit          is_ld;
    bit          ex;
    int          len;
    int          d;
    bit          done;
    bit          full;
    logic [31:0] nxt;
    is_ld = exp_is_load(op);
    ex    = exp_runs(op, bflag);
    len   = ex ? exp_arlen(op, bl) : 0;
    nxt   = addr + ((32'(len) + 32'd1) << sz);
    op_valid = 1'b1; op_byte = op; req_is_burst = bflag; src_addr = addr;
    ctl_src_inc = inc; ctl_burst_len = bl; ctl_size = sz; chan_id = ch;
    #1;
    check(op_ready == 1'b1, "R10", "op_ready when idle", op_ready, 1);
    @(posedge clk);
    @(negedge clk);
    // Scramble the inputs so that a result taken from them late is caught.
    op_valid = 1'b0; op_byte = 8'($urandom); src_addr = $urandom;
    ctl_burst_len = 5'($urandom); ctl_size = 3'($urandom); chan_id = 3'($urandom);
    ctl_src_inc = 1'($urandom);
    #1;
    if (!is_ld) begin
      check(pc_adv == 1'b0 && busy == 1'b0 && arvalid == 1'b0, "R1", "non-load ignored",
            {pc_adv, busy, arvalid}, 0);
    end else if (!ex) begin
      check(pc_adv == 1'b1, "R5", "skip pc_adv", pc_adv, 1);
      check(busy == 1'b0 && arvalid == 1'b0 && addr_wr == 1'b0, "R5", "skip quiet",
            {busy, arvalid, addr_wr}, 0);
      @(negedge clk); #1;
      check(pc_adv == 1'b0, "R5", "skip pulse width", pc_adv, 0);
    end else begin
      check(busy == 1'b1 && op_ready == 1'b0, "R10", "busy after accept",
            {busy, op_ready}, 2'b10);
      check(pc_adv == 1'b0, "R10", "no pc_adv on issue", pc_adv, 0);
      d = $urandom_range(0, 2);
      repeat (d) begin
        check(arvalid == 1'b1, "R6", "arvalid held", arvalid, 1);
        @(posedge clk); @(negedge clk); #1;
      end
      check(arvalid == 1'b1, "R6", "arvalid", arvalid, 1);
      check(araddr == addr, "R6", "araddr", araddr, addr);
      check(arsize == sz, "R6", "arsize", arsize, sz);
      check(arburst == (inc ? 2'b01 : 2'b00), "R6", "arburst", arburst, inc ? 1 : 0);
      check(int'(arlen) == len, len_req(op, bl), "arlen", arlen, len);
      arready = 1'b1;
      @(posedge clk); @(negedge clk);
      arready = 1'b0;
      // Offer an opcode while busy: it must not be taken.
      op_valid = 1'b1; op_byte = 8'h04;
      for (int beat = 0; beat <= len; beat++) begin
        do begin
          full      = ($urandom_range(0, 99) < full_pct);
          fifo_full = full;
          rvalid    = ($urandom_range(0, 3) != 0);
          rdata     = $urandom;
          rlast     = (beat == len);
          #1;
          check(rready == !full, "R7", "rready vs full", rready, !full);
          check(fifo_wr == (rvalid && !full), "R7", "fifo_wr", fifo_wr, rvalid && !full);
          if (fifo_wr) begin
            check(fifo_wdata == rdata, "R7", "fifo_wdata", fifo_wdata, rdata);
            check(fifo_wtag == ch, "R7", "fifo_wtag", fifo_wtag, ch);
          end
          check(busy == 1'b1 && op_ready == 1'b0 && arvalid == 1'b0, "R10", "busy in data",
                {busy, op_ready, arvalid}, 3'b100);
          done = rvalid && !full;
          @(posedge clk); @(negedge clk);
        end while (!done);
      end
      op_valid = 1'b0; rvalid = 1'b0; rlast = 1'b0; fifo_full = 1'b0;
      #1;
      check(pc_adv == 1'b1 && busy == 1'b0, "R8", "retire", {pc_adv, busy}, 2'b10);
      check(arvalid == 1'b0, "R10", "no accept while busy", arvalid, 0);
      check(addr_wr == inc, "R9", "addr_wr", addr_wr, inc);
      if (inc) check(addr_next == nxt, "R9", "addr_next", addr_next, nxt);
      @(negedge clk); #1;
      check(pc_adv == 1'b0 && addr_wr == 1'b0, "R8", "retire pulse width", {pc_adv, addr_wr}, 0);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report_and_end();
  end

  initial begin
    logic [7:0] op;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; op_valid = 1'b0; op_byte = 8'h00; req_is_burst = 1'b0;
    src_addr = '0; ctl_src_inc = 1'b0; ctl_burst_len = 5'd1; ctl_size = 3'd0;
    chan_id = '0; arready = 1'b0; rvalid = 1'b0; rdata = '0; rlast = 1'b0; fifo_full = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(op_ready == 1'b1 && busy == 1'b0, "R10", "reset idle", {op_ready, busy}, 2'b10);
    check(arvalid == 1'b0 && rready == 1'b0 && fifo_wr == 1'b0 && pc_adv == 1'b0, "R5",
          "reset outputs quiet", {arvalid, rready, fifo_wr, pc_adv}, 0);
    @(negedge clk);

    // Directed corner cases.
    run_op(8'h04, 1'b0, 32'h0000_1000, 1'b1, 5'd4,  3'd2, 3'd1, 0);   // R2 unconditional
    run_op(8'h04, 1'b1, 32'h0000_2000, 1'b0, 5'd3,  3'd1, 3'd2, 0);   // R2 flag ignored, R9 no inc
    run_op(8'h06, 1'b0, 32'h0000_2200, 1'b1, 5'd2,  3'd0, 3'd3, 0);   // R2 bit1 with x=0
    run_op(8'h05, 1'b0, 32'h0000_3000, 1'b1, 5'd8,  3'd2, 3'd4, 0);   // R3 forced single beat
    run_op(8'h05, 1'b1, 32'h0000_4000, 1'b1, 5'd8,  3'd2, 3'd5, 0);   // R5 single skipped
    run_op(8'h07, 1'b1, 32'h0000_5000, 1'b1, 5'd16, 3'd3, 3'd6, 40);  // R4 full burst, R7 stalls
    run_op(8'h07, 1'b0, 32'h0000_6000, 1'b1, 5'd16, 3'd3, 3'd7, 0);   // R5 burst skipped
    run_op(8'h04, 1'b0, 32'h0000_7000, 1'b1, 5'd0,  3'd2, 3'd0, 0);   // R11 zero length
    run_op(8'h07, 1'b1, 32'hFFFF_FFF0, 1'b1, 5'd31, 3'd0, 3'd1, 20);  // R11 clamp, R9 wrap
    run_op(8'h34, 1'b1, 32'h0000_8000, 1'b1, 5'd4,  3'd2, 3'd2, 0);   // R1 not a load
    run_op(8'h00, 1'b0, 32'h0000_8100, 1'b1, 5'd4,  3'd2, 3'd2, 0);   // R1 not a load

    // Constrained random mix.
    for (int i = 0; i < 200; i++) begin
      case ($urandom_range(0, 5))
        0: op = 8'h04;
        1: op = 8'h05;
        2: op = 8'h06;
        3, 4: op = 8'h07;
        default: op = 8'($urandom);
      endcase
      run_op(op, 1'($urandom), $urandom, 1'($urandom), 5'($urandom), 3'($urandom_range(0, 3)),
             3'($urandom), $urandom_range(0, 50));
    end
    report_and_end();
  end
endmodule